// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers asynchronous serial frames from a single input line. A one-cycle `tick` pulse arrives at sixteen times the baud rate. The receiver samples the line only on those ticks. It locks its bit phase to the falling edge of the start bit and decides each bit by a majority vote over three samples taken around the middle of the bit.

The mode input selects one of two frame shapes:
- An eight-data-bit frame.
- A nine-data-bit frame, used for address/data tagging on multidrop links.

When the stop bit has been judged, the block presents the assembled byte and one extra bit, and pulses a completion strobe. A start bit that does not hold low through its middle is discarded. A stop bit that reads low raises a sticky framing-error flag, which only an explicit clear input can lower. Baud tick generation, decisions about whether to accept a frame, and any register access are handled outside this block.

Top module: `oversample_rx`

## Requirements
- R1: After reset, `dataOut` is 0, `extraBit` is 0, `frameDone` is 0 and `frameErr` is 0.
- R2: With `rxEn` high, a frame begins on a tick where the line reads 0 and the preceding tick read 1. That tick is phase 0 of the start bit. Each later tick advances the phase, and phases 0..15 make up one bit period.
- R3: Each bit value is the majority of the line samples taken at phases 7, 8 and 9 of that bit. A single sample that differs from the other two does not change the decided value. A pulse that falls between two ticks is never seen.
- R4: If the voted start bit is 1, the frame is abandoned without any strobe, and the receiver goes back to hunting for a falling edge.
- R5: Data bits arrive least significant bit first. With `nineBit`=0 the frame is start, 8 data bits and stop, and `extraBit` takes the voted stop value. With `nineBit`=1 the frame is start, 9 data bits and stop. `dataOut` takes the first 8 data bits and `extraBit` takes the 9th.
- R6: `frameDone` is a one-clock pulse issued on the tick at phase 9 of the stop bit: tick 153 after the start edge in 8-bit mode, and tick 169 in 9-bit mode. `dataOut` and `extraBit` update at that same edge and hold until the next frame.
- R7: A voted stop bit of 0 still produces the strobe and also sets `frameErr`. Later valid frames leave `frameErr` set. Only `errClr` clears it.
- R8: While `rxEn` is low nothing is received. Lowering `rxEn` in the middle of a frame abandons that frame without a strobe.
- R9: After a frame ends, a new frame can start only once the line has been sampled high on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at 16x the baud rate |
| rxEn | input | 1 | Receive enable |
| nineBit | input | 1 | 1 selects the 9-data-bit frame; latched at the start edge |
| lineIn | input | 1 | Serial input line, idle high |
| errClr | input | 1 | Clears the framing-error flag |
| dataOut | output | 8 | Last received data byte |
| extraBit | output | 1 | 9th data bit, or the stop bit in 8-bit mode |
| frameDone | output | 1 | One-clock final-shift strobe |
| frameErr | output | 1 | Sticky framing-error flag |

## Verification
On every cycle, the embedded assertions check the following:
- The control leaves idle only on an enabled tick.
- The phase counter moves only on ticks.
- Dropping the enable forces idle.
- The bit counter stays in range.
- The completion strobe lasts a single clock.
- The error flag rises only together with a strobe and then persists until cleared.

Several behaviours can only be shown by the directed scenarios, because they depend on bit values decided over many ticks:
- The exact vote outcome when one sample is an outlier.
- The immunity to glitches that fall between ticks.
- The abandonment of a false start.
- The least-significant-bit-first assembly in both frame lengths.
- The strobe landing on tick 153 or 169.
- The need to see the line high before a new frame can start.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeEarly;  // capture first vote sample
    logic takeMid;    // capture second vote sample
    logic shiftIn;    // shift voted data bit into the frame register
    logic finish;     // final shift: publish frame, judge stop bit
    logic mode9;      // frame length latched at start edge
  } rxStrobe_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxEn,
  input  logic      nineBit,
  input  logic      lineS,
  input  logic      votedNow,
  output rxStrobe_t strobes
);

  localparam int PH_W     = $clog2(OVERSAMPLE);
  localparam int VOTE_MID = OVERSAMPLE / 2;
  localparam int VOTE_LO  = VOTE_MID - 1;
  localparam int VOTE_HI  = VOTE_MID + 1;
  localparam int LAST_PH  = OVERSAMPLE - 1;
  localparam int CNT_W    = $clog2(DATA_BITS + 2);

  rxState_t        state;
  logic [PH_W-1:0] phase;
  logic [CNT_W-1:0] bitIdx;
  logic            prevHigh;
  logic            mode9;

  logic active, atLo, atMid, atHi, atLast;
  logic [CNT_W-1:0] bitsWanted;
  logic [PH_W-1:0]  phaseNext;

  always_comb begin
    active     = tick && rxEn;
    atLo       = (phase == PH_W'(VOTE_LO));
    atMid      = (phase == PH_W'(VOTE_MID));
    atHi       = (phase == PH_W'(VOTE_HI));
    atLast     = (phase == PH_W'(LAST_PH));
    bitsWanted = mode9 ? CNT_W'(DATA_BITS + 1) : CNT_W'(DATA_BITS);
    phaseNext  = atLast ? '0 : phase + 1'b1;
  end

  always_comb begin
    strobes.takeEarly = active && (state != ST_IDLE) && atLo;
    strobes.takeMid   = active && (state != ST_IDLE) && atMid;
    strobes.shiftIn   = active && (state == ST_DATA) && atHi;
    strobes.finish    = active && (state == ST_STOP) && atHi;
    strobes.mode9     = mode9;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitIdx   <= '0;
      prevHigh <= 1'b0;
      mode9    <= 1'b0;
    end else if (!rxEn) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitIdx   <= '0;
      prevHigh <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          prevHigh <= lineS;
          if (prevHigh && !lineS) begin
            state  <= ST_START;
            phase  <= PH_W'(1);
            bitIdx <= '0;
            mode9  <= nineBit;
          end
        end
        ST_START: begin
          phase <= phaseNext;
          if (atHi && votedNow) begin
            state    <= ST_IDLE;
            phase    <= '0;
            prevHigh <= 1'b0;
          end else if (atLast) begin
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          phase <= phaseNext;
          if (atHi) bitIdx <= bitIdx + 1'b1;
          if (atLast && (bitIdx == bitsWanted)) state <= ST_STOP;
        end
        ST_STOP: begin
          phase <= phaseNext;
          if (atHi) begin
            state    <= ST_IDLE;
            phase    <= '0;
            prevHigh <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: idle is left only on an enabled tick
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(tick && rxEn)) |=> (state == ST_IDLE));

  // R2: phase advances only on ticks
  assert_phase_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && rxEn) |=> $stable(phase));

  // R8: losing enable forces idle
  assert_enable_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !rxEn) |=> (state == ST_IDLE));

  // R5: data bit counter never exceeds the longest frame
  assert_bitidx_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= CNT_W'(DATA_BITS + 1));

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineIn,
  input  logic                 errClr,
  input  rxStrobe_t            strobes,
  output logic                 lineS,
  output logic                 votedNow,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 extraBit,
  output logic                 frameDone,
  output logic                 frameErr
);

  localparam int SH_W = DATA_BITS + 1;

  logic            sampEarly, sampMid;
  logic [SH_W-1:0] shReg;

  always_comb
    votedNow = (sampEarly & sampMid) | (sampEarly & lineS) | (sampMid & lineS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineS     <= 1'b1;
      sampEarly <= 1'b1;
      sampMid   <= 1'b1;
      shReg     <= '0;
    end else begin
      lineS <= lineIn;
      if (strobes.takeEarly) sampEarly <= lineS;
      if (strobes.takeMid)   sampMid   <= lineS;
      if (strobes.shiftIn)   shReg     <= {votedNow, shReg[SH_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      extraBit  <= 1'b0;
      frameDone <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      frameDone <= strobes.finish;
      if (strobes.finish) begin
        dataOut  <= strobes.mode9 ? shReg[DATA_BITS-1:0] : shReg[SH_W-1:1];
        extraBit <= strobes.mode9 ? shReg[SH_W-1] : votedNow;
      end
      if (strobes.finish && !votedNow) frameErr <= 1'b1;
      else if (errClr)                 frameErr <= 1'b0;
    end
  end

  // R6: strobe lasts one clock
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R6: published frame holds between strobes
  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> ($stable(dataOut) && $stable(extraBit)));

  // R7: error flag persists until cleared
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !errClr) |=> frameErr);

  // R7: error flag rises only together with a strobe
  assert_err_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> frameDone);

endmodule

// File: rtl/oversample_rx.sv
module oversample_rx
  import rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 rxEn,
  input  logic                 nineBit,
  input  logic                 lineIn,
  input  logic                 errClr,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 extraBit,
  output logic                 frameDone,
  output logic                 frameErr
);

  rxStrobe_t strobes;
  logic      lineS;
  logic      votedNow;

  rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .rxEn    (rxEn),
    .nineBit (nineBit),
    .lineS   (lineS),
    .votedNow(votedNow),
    .strobes (strobes)
  );

  rx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .errClr   (errClr),
    .strobes  (strobes),
    .lineS    (lineS),
    .votedNow (votedNow),
    .dataOut  (dataOut),
    .extraBit (extraBit),
    .frameDone(frameDone),
    .frameErr (frameErr)
  );

endmodule

// File: tb/oversample_rx_tb_top.sv
`timescale 1ns/1ps
module oversample_rx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxEn = 1'b0;
  logic       nineBit = 1'b0;
  logic       lineIn = 1'b1;
  logic       errClr = 1'b0;
  logic [7:0] dataOut;
  logic       extraBit;
  logic       frameDone;
  logic       frameErr;

  int checks = 0;
  int fails = 0;
  int tickNo = 0;
  int doneTick = -1;
  int doneCount = 0;
  logic [7:0] gotData = '0;
  logic gotExtra = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  oversample_rx dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .rxEn(rxEn), .nineBit(nineBit),
    .lineIn(lineIn), .errClr(errClr), .dataOut(dataOut), .extraBit(extraBit),
    .frameDone(frameDone), .frameErr(frameErr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One 16x tick; line held at v for two clocks before the sampling edge.
  task automatic doTick(input logic v, input bit glitch);
    lineIn = v;
    @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (frameDone) begin
      doneCount++;
      doneTick = tickNo;
      gotData  = dataOut;
      gotExtra = extraBit;
    end
    if (glitch) begin
      lineIn = ~v;
      @(negedge clk);
      lineIn = v;
    end
    tickNo++;
  endtask

  task automatic idleTicks(input logic v, input int n);
    for (int i = 0; i < n; i++) doTick(v, 1'b0);
  endtask

  task automatic sendFrame(input logic [8:0] bits, input bit nine, input logic stopV,
                           input int flipBit, input int flipPh, input bit glitchy,
                           input logic tailV, input int tailN);
    int nb;
    logic v;
    nb = nine ? 9 : 8;
    nineBit = nine;
    doneCount = 0;
    doneTick = -1;
    tickNo = -2;
    idleTicks(1'b1, 2);
    for (int b = 0; b <= nb + 1; b++) begin
      for (int ph = 0; ph < 16; ph++) begin
        if (b == 0) v = 1'b0;
        else if (b <= nb) v = bits[b-1];
        else v = stopV;
        if (b == flipBit && ph == flipPh) v = ~v;
        doTick(v, glitchy && (ph == 3 || ph == 8));
      end
    end
    idleTicks(tailV, tailN);
  endtask

  task automatic t_reset;
    chk(dataOut == 8'h00, "R1", "reset dataOut", dataOut, 0);
    chk(extraBit == 1'b0, "R1", "reset extraBit", extraBit, 0);
    chk(frameDone == 1'b0, "R1", "reset frameDone", frameDone, 0);
    chk(frameErr == 1'b0, "R1", "reset frameErr", frameErr, 0);
  endtask

  task automatic t_basic8;
    sendFrame(9'h0A5, 1'b0, 1'b1, -1, 0, 1'b0, 1'b1, 4);
    chk(doneCount == 1, "R6", "8-bit strobe count", doneCount, 1);
    chk(doneTick == 153, "R6", "8-bit strobe tick", doneTick, 153);
    chk(gotData == 8'hA5, "R5", "8-bit data A5", gotData, 8'hA5);
    chk(gotExtra == 1'b1, "R5", "8-bit extra=stop", gotExtra, 1);
    chk(dataOut == 8'hA5, "R6", "data held after strobe", dataOut, 8'hA5);
    chk(frameErr == 1'b0, "R7", "no error on good stop", frameErr, 0);
    sendFrame(9'h03C, 1'b0, 1'b1, -1, 0, 1'b0, 1'b1, 4);
    chk(gotData == 8'h3C, "R5", "8-bit data 3C", gotData, 8'h3C);
  endtask

  task automatic t_nine;
    sendFrame(9'h1C3, 1'b1, 1'b1, -1, 0, 1'b0, 1'b1, 4);
    chk(doneTick == 169, "R6", "9-bit strobe tick", doneTick, 169);
    chk(gotData == 8'hC3, "R5", "9-bit data C3", gotData, 8'hC3);
    chk(gotExtra == 1'b1, "R5", "9-bit ninth=1", gotExtra, 1);
    sendFrame(9'h05A, 1'b1, 1'b1, -1, 0, 1'b0, 1'b1, 4);
    chk(gotData == 8'h5A, "R5", "9-bit data 5A", gotData, 8'h5A);
    chk(gotExtra == 1'b0, "R5", "9-bit ninth=0", gotExtra, 0);
  endtask

  task automatic t_outlier;
    sendFrame(9'h096, 1'b0, 1'b1, 3, 7, 1'b0, 1'b1, 4);
    chk(gotData == 8'h96, "R3", "outlier phase 7", gotData, 8'h96);
    sendFrame(9'h096, 1'b0, 1'b1, 5, 8, 1'b0, 1'b1, 4);
    chk(gotData == 8'h96, "R3", "outlier phase 8", gotData, 8'h96);
    sendFrame(9'h096, 1'b0, 1'b1, 8, 9, 1'b0, 1'b1, 4);
    chk(gotData == 8'h96, "R3", "outlier phase 9", gotData, 8'h96);
    sendFrame(9'h096, 1'b0, 1'b1, 9, 8, 1'b0, 1'b1, 4);
    chk(frameErr == 1'b0 && gotExtra == 1'b1, "R3", "stop outlier ignored",
        frameErr, 0);
    sendFrame(9'h0F0, 1'b0, 1'b1, 0, 8, 1'b0, 1'b1, 4);
    chk(doneCount == 1 && gotData == 8'hF0, "R3", "start outlier ignored",
        doneCount, 1);
  endtask

  task automatic t_glitch;
    sendFrame(9'h069, 1'b0, 1'b1, -1, 0, 1'b1, 1'b1, 4);
    chk(gotData == 8'h69, "R3", "between-tick glitches", gotData, 8'h69);
    chk(doneCount == 1, "R3", "glitch frame strobe count", doneCount, 1);
  endtask

  task automatic t_falseStart;
    doneCount = 0;
    idleTicks(1'b1, 3);
    idleTicks(1'b0, 7);
    idleTicks(1'b1, 200);
    chk(doneCount == 0, "R4", "short low start rejected", doneCount, 0);
    idleTicks(1'b0, 1);
    idleTicks(1'b1, 200);
    chk(doneCount == 0, "R4", "single-tick low rejected", doneCount, 0);
    sendFrame(9'h081, 1'b0, 1'b1, -1, 0, 1'b0, 1'b1, 4);
    chk(gotData == 8'h81 && doneTick == 153, "R4", "frame after false start",
        gotData, 8'h81);
  endtask

  task automatic t_badStop;
    sendFrame(9'h0C7, 1'b0, 1'b0, -1, 0, 1'b0, 1'b0, 200);
    chk(frameErr == 1'b1, "R7", "bad stop sets error", frameErr, 1);
    chk(gotData == 8'hC7 && gotExtra == 1'b0, "R7", "bad stop still strobes",
        gotExtra, 0);
    chk(doneCount == 1, "R9", "no restart while line stays low", doneCount, 1);
    sendFrame(9'h055, 1'b0, 1'b1, -1, 0, 1'b0, 1'b1, 4);
    chk(gotData == 8'h55, "R9", "frame after line high", gotData, 8'h55);
    chk(frameErr == 1'b1, "R7", "good frame keeps error", frameErr, 1);
    @(negedge clk) errClr = 1'b1;
    @(negedge clk) errClr = 1'b0;
    chk(frameErr == 1'b0, "R7", "errClr clears error", frameErr, 0);
  endtask

  task automatic t_enable;
    rxEn = 1'b0;
    sendFrame(9'h0E1, 1'b0, 1'b1, -1, 0, 1'b0, 1'b1, 4);
    chk(doneCount == 0, "R8", "disabled: no strobe", doneCount, 0);
    chk(dataOut == 8'h55, "R8", "disabled: data unchanged", dataOut, 8'h55);
    rxEn = 1'b1;
    doneCount = 0;
    idleTicks(1'b1, 3);
    idleTicks(1'b0, 40);
    rxEn = 1'b0;
    idleTicks(1'b0, 2);
    rxEn = 1'b1;
    idleTicks(1'b1, 200);
    chk(doneCount == 0, "R8", "mid-frame disable abandons", doneCount, 0);
    sendFrame(9'h033, 1'b0, 1'b1, -1, 0, 1'b0, 1'b1, 4);
    chk(gotData == 8'h33, "R8", "frame after re-enable", gotData, 8'h33);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    rxEn = 1'b1;
    t_basic8();
    t_nine();
    t_outlier();
    t_glitch();
    t_falseStart();
    t_badStop();
    t_enable();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule